// File: doc/BRIEF.md
# Prescaled Cycle Count Register

This block holds a per-processor register of twice the count width (64 bits at the default width of 32). Its low half is a free-running unsigned count that moves forward by one after every N enabled core clocks. N is a divide ratio taken from an input and is meant to stay fixed for a given configuration. Its high half is an offset that system software loads through a privileged write strobe. The offset has no tie to time, and zero is a legal value.

A read strobe captures both halves from the same clock edge into a read register. This works like a single instruction-level read. The same capture also produces the sum of the two halves, taken modulo 2^CNT_W. Thread-accounting software uses this sum as the running cycle total of the current thread.

Each instance keeps all of its state to itself. A processor that needs a counter gets its own instance.

Top module: `cyc_tally_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has count half = 0, offset half = 0, prescale phase = 0, `rd_valid` = 0, `rd_data` = 0 and `rd_total` = 0.
- R2: With `en` held high and an effective ratio N, the count half grows by exactly one on every Nth enabled edge. The first step comes N enabled edges after reset, or after `en` goes high. With N = 1 it steps on every enabled edge.
- R3: The effective ratio is `div_ratio` when that value lies in 1..MAX_DIV (16 by default). A value of 0 acts as 1, and a value above MAX_DIV acts as MAX_DIV.
- R4: After all ones (0xFFFFFFFF at the default width), the next step of the count half gives 0. There is no saturation and no overflow flag.
- R5: While `en` is low, the count half holds and the prescale phase returns to zero.
- R6: `off_wr` high at an edge loads `off_wdata` into the offset half and leaves the count half and the prescale phase untouched. A write and a count step on the same edge both take effect.
- R7: `rd_en` high at an edge makes `rd_valid` 1 in the following cycle. `rd_data` then shows {offset half, count half}, with the offset in the upper CNT_W bits, as both halves stood just before that edge. Without `rd_en`, `rd_valid` is 0 and `rd_data` keeps its value.
- R8: `rd_total` is updated together with `rd_data` and equals (offset half + count half) mod 2^CNT_W taken from the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counting enable |
| div_ratio | input | DIV_W | Divide ratio N (5 bits by default) |
| off_wr | input | 1 | Offset write strobe |
| off_wdata | input | CNT_W | Value written to the offset half |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 2*CNT_W | Captured {offset, count} |
| rd_total | output | CNT_W | Captured offset plus count, wrapped |

## Verification
Two operations can land on one edge: an offset write and a count step. With N = 1 and `en` high, every edge steps the count. A random run at that ratio therefore places offset writes on step edges many times, and a table entry starts its run with a write on the first enabled edge. A reference model in the bench applies both updates on each edge. Later reads must show the new offset next to the advanced count, and the wrapped sum must agree with the model.

// File: rtl/cyc_tally_pkg.sv
package cyc_tally_pkg;

  // Effective divide ratio: zero behaves as one, oversize values clamp.
  function automatic int unsigned f_eff_div(int unsigned raw, int unsigned max_div);
    if (raw == 0) return 1;
    if (raw > max_div) return max_div;
    return raw;
  endfunction

  // True when the phase has reached the last slot of the current period.
  function automatic logic f_phase_last(int unsigned phase, int unsigned eff_div);
    return (phase + 1) >= eff_div;
  endfunction

  // Wrapping sum; the caller truncates to its own width.
  function automatic logic [63:0] f_wrap_sum(logic [63:0] a, logic [63:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/cyc_prescaler.sv
module cyc_prescaler
  import cyc_tally_pkg::*;
#(
  parameter int MAX_DIV = 16,
  parameter int DIV_W   = 5,
  parameter int PH_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [PH_W-1:0]  phase
);

  generate
    if (MAX_DIV == 1) begin : g_direct
      // Ratio fixed at one: every enabled edge is a step.
      assign tick  = en;
      assign phase = '0;
    end else begin : g_count
      logic [PH_W-1:0] ph_q;
      logic            last;

      always_comb last = f_phase_last(32'(ph_q), f_eff_div(32'(div), 32'(MAX_DIV)));

      assign tick = en && last;

      always_ff @(posedge clk) begin
        if (rst || !en || last) ph_q <= '0;
        else                    ph_q <= ph_q + PH_W'(1);
      end

      assign phase = ph_q;
    end
  endgenerate

endmodule

// File: rtl/cyc_count_half.sv
module cyc_count_half #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/cyc_offset_half.sv
module cyc_offset_half #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] off
);

  always_ff @(posedge clk) begin
    if (rst)     off <= '0;
    else if (wr) off <= wdata;
  end

endmodule

// File: rtl/cyc_read_port.sv
module cyc_read_port
  import cyc_tally_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [CNT_W-1:0]   off,
  input  logic [CNT_W-1:0]   cnt,
  output logic               rd_valid,
  output logic [2*CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0]   rd_total
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_total <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data  <= {off, cnt};
        rd_total <= CNT_W'(f_wrap_sum(64'(off), 64'(cnt)));
      end
    end
  end

endmodule

// File: rtl/cyc_tally_reg.sv
module cyc_tally_reg
  import cyc_tally_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MAX_DIV = 16,
  parameter int DIV_W   = $clog2(MAX_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DIV_W-1:0]   div_ratio,
  input  logic               off_wr,
  input  logic [CNT_W-1:0]   off_wdata,
  input  logic               rd_en,
  output logic               rd_valid,
  output logic [2*CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0]   rd_total
);

  localparam int PH_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  // Named internal events, visible to the bound checker.
  logic             tick_w;
  logic [PH_W-1:0]  phase_w;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] off_q;

  cyc_prescaler #(.MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .PH_W(PH_W)) u_presc (
    .clk(clk), .rst(rst), .en(en), .div(div_ratio), .tick(tick_w), .phase(phase_w)
  );

  cyc_count_half #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick_w), .cnt(cnt_q)
  );

  cyc_offset_half #(.CNT_W(CNT_W)) u_offset (
    .clk(clk), .rst(rst), .wr(off_wr), .wdata(off_wdata), .off(off_q)
  );

  cyc_read_port #(.CNT_W(CNT_W)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .off(off_q), .cnt(cnt_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_total(rd_total)
  );

endmodule

// File: rtl/cyc_tally_chk.sv
module cyc_tally_chk #(
  parameter int CNT_W   = 32,
  parameter int MAX_DIV = 16,
  parameter int DIV_W   = 5,
  parameter int PH_W    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [DIV_W-1:0]   div,
  input logic               off_wr,
  input logic [CNT_W-1:0]   off_wdata,
  input logic               rd_en,
  input logic               rd_valid,
  input logic [2*CNT_W-1:0] rd_data,
  input logic [CNT_W-1:0]   rd_total,
  input logic               tick,
  input logic [PH_W-1:0]    ph,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   off
);

  // Enabled edges since the last step, counted independently of the phase.
  int unsigned gap_q;
  int unsigned eff_n;

  always_comb begin
    if (div == '0)                   eff_n = 1;
    else if (32'(div) > 32'(MAX_DIV)) eff_n = 32'(MAX_DIV);
    else                             eff_n = 32'(div);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || tick) gap_q <= 0;
    else                    gap_q <= gap_q + 1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && off == '0 && ph == '0 && !rd_valid && rd_data == '0 && rd_total == '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + CNT_W'(1));

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q + 1) == eff_n);

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '1) |=> cnt == '0);

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_tick_gated_r5: assert property (@(posedge clk) disable iff (rst)
    tick |-> en);

  p_phase_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ph == '0);

  p_off_load_r6: assert property (@(posedge clk) disable iff (rst)
    off_wr |=> off == $past(off_wdata));

  p_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !off_wr |=> $stable(off));

  p_rd_sample_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_valid && rd_data == {$past(off), $past(cnt)}));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data) && $stable(rd_total)));

  p_total_sum_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_total == CNT_W'(rd_data[2*CNT_W-1:CNT_W] + rd_data[CNT_W-1:0]));

endmodule

bind cyc_tally_reg cyc_tally_chk #(
  .CNT_W(CNT_W), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .PH_W(PH_W)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .div(div_ratio), .off_wr(off_wr),
  .off_wdata(off_wdata), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_total(rd_total), .tick(tick_w), .ph(phase_w), .cnt(cnt_q), .off(off_q)
);

// File: tb/cyc_tally_reg_tb_top.sv
`timescale 1ns/1ps
module cyc_tally_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst, en, off_wr, rd_en;
  logic [4:0]  div_ratio;
  logic [31:0] off_wdata;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [31:0] rd_total;

  // Narrow instance for reaching the all-ones count quickly.
  logic        w_rst, w_en, w_off_wr, w_rd_en;
  logic [4:0]  w_div;
  logic [5:0]  w_off_wdata;
  logic        w_rd_valid;
  logic [11:0] w_rd_data;
  logic [5:0]  w_rd_total;

  always #5 clk = ~clk;

  cyc_tally_reg dut_i (
    .clk(clk), .rst(rst), .en(en), .div_ratio(div_ratio), .off_wr(off_wr),
    .off_wdata(off_wdata), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_total(rd_total)
  );

  cyc_tally_reg #(.CNT_W(6)) wrap_i (
    .clk(clk), .rst(w_rst), .en(w_en), .div_ratio(w_div), .off_wr(w_off_wr),
    .off_wdata(w_off_wdata), .rd_en(w_rd_en), .rd_valid(w_rd_valid), .rd_data(w_rd_data),
    .rd_total(w_rd_total)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model of the default-width instance.
  logic [31:0] m_cnt, m_off, m_tot;
  logic [63:0] m_rd;
  logic        m_rdv;
  int          m_gap;

  typedef struct packed {
    logic [4:0]  div;
    logic [31:0] cyc;
    logic [31:0] off;
    logic [31:0] cnt;
    logic [31:0] tot;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{5'd1,  32'd5,  32'h0000_0010, 32'd5, 32'h0000_0015},
    '{5'd3,  32'd10, 32'hFFFF_FFFF, 32'd3, 32'h0000_0002},
    '{5'd16, 32'd40, 32'h0000_0100, 32'd2, 32'h0000_0102},
    '{5'd7,  32'd7,  32'h0000_0000, 32'd1, 32'h0000_0001},
    '{5'd16, 32'd15, 32'h0000_0005, 32'd0, 32'h0000_0005},
    '{5'd0,  32'd4,  32'h0000_0008, 32'd4, 32'h0000_000C}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One clock: model follows the inputs seen at the edge; returns at the falling edge.
  task automatic step();
    int n;
    @(posedge clk);
    n = (div_ratio == 0) ? 1 : int'(div_ratio);
    if (rst) begin
      m_cnt = 0; m_off = 0; m_gap = 0; m_rdv = 0; m_rd = 0; m_tot = 0;
    end else begin
      m_rdv = rd_en;
      if (rd_en) begin
        m_rd  = {m_off, m_cnt};
        m_tot = m_off + m_cnt;
      end
      if (en) begin
        m_gap++;
        if (m_gap >= n) begin
          m_cnt = m_cnt + 1;
          m_gap = 0;
        end
      end else m_gap = 0;
      if (off_wr) m_off = off_wdata;
    end
    @(negedge clk);
  endtask

  task automatic cmp_model(input string tag);
    chk(rd_valid == m_rdv, {tag, " R7 valid"}, 64'(rd_valid), 64'(m_rdv));
    if (m_rdv) begin
      chk(rd_data == m_rd, {tag, " R7 data"}, rd_data, m_rd);
      chk(rd_total == m_tot, {tag, " R8 total"}, 64'(rd_total), 64'(m_tot));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; off_wr = 1'b0; rd_en = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic read_now();
    en = 1'b0; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    div_ratio = 5'd1; off_wdata = '0;
    w_rst = 1'b1; w_en = 1'b0; w_off_wr = 1'b0; w_rd_en = 1'b0; w_div = 5'd1; w_off_wdata = '0;
    rst = 1'b1; en = 1'b1; off_wr = 1'b1; off_wdata = 32'hDEAD_BEEF; rd_en = 1'b1;
    step(); step(); step();
    // R1: reset wins over every strobe
    chk(rd_valid == 1'b0, "R1 valid", 64'(rd_valid), 64'd0);
    chk(rd_data == 64'd0, "R1 data", rd_data, 64'd0);
    chk(rd_total == 32'd0, "R1 total", 64'(rd_total), 64'd0);
    rst = 1'b0; en = 1'b0; off_wr = 1'b0; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk(rd_valid && rd_data == 64'd0, "R1 state read", rd_data, 64'd0);

    // Vector table: ratio, enabled edges, offset written on the first enabled edge.
    for (int i = 0; i < 6; i++) begin
      do_reset();
      div_ratio = TBL[i].div;
      en = 1'b1; off_wr = 1'b1; off_wdata = TBL[i].off;
      step();
      off_wr = 1'b0;
      repeat (int'(TBL[i].cyc) - 1) step();
      read_now();
      chk(rd_data == {TBL[i].off, TBL[i].cnt}, "R2 R3 R6 table data", rd_data, {TBL[i].off, TBL[i].cnt});
      chk(rd_total == TBL[i].tot, "R8 table total", 64'(rd_total), 64'(TBL[i].tot));
    end

    // R5: disable clears the phase and freezes the count.
    do_reset();
    div_ratio = 5'd4; en = 1'b1;
    repeat (6) step();
    en = 1'b0;
    repeat (3) step();
    en = 1'b1;
    repeat (3) step();
    read_now();
    chk(rd_data[31:0] == 32'd1, "R5 phase restart", 64'(rd_data[31:0]), 64'd1);
    en = 1'b1;
    repeat (4) step();
    read_now();
    chk(rd_data[31:0] == 32'd2, "R5 step after N", 64'(rd_data[31:0]), 64'd2);
    step();
    chk(rd_valid == 1'b0, "R7 valid drops", 64'(rd_valid), 64'd0);
    chk(rd_data[31:0] == 32'd2, "R7 data held", 64'(rd_data[31:0]), 64'd2);

    // R3: oversize ratio clamps to 16.
    do_reset();
    div_ratio = 5'd31; en = 1'b1;
    repeat (32) step();
    read_now();
    chk(rd_data[31:0] == 32'd2, "R3 clamp", 64'(rd_data[31:0]), 64'd2);

    // R6 R7 R8: random writes, reads and enables against the model, N=1 then N=5.
    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      div_ratio = (pass == 0) ? 5'd1 : 5'd5;
      for (int c = 0; c < 400; c++) begin
        en        = ($urandom % 4) != 0;
        off_wr    = ($urandom % 3) == 0;
        off_wdata = $urandom;
        rd_en     = ($urandom % 2) == 0;
        step();
        cmp_model("rand");
      end
      en = 1'b0; off_wr = 1'b0; rd_en = 1'b0;
    end

    // R4: wrap from all ones for every ratio 1..16 on the narrow instance.
    for (int n = 1; n <= 16; n++) begin
      w_rst = 1'b1; w_en = 1'b0; w_rd_en = 1'b0;
      step();
      w_rst = 1'b0; w_div = 5'(n); w_en = 1'b1; w_off_wr = 1'b1; w_off_wdata = 6'd1;
      step();
      w_off_wr = 1'b0;
      repeat (63 * n - 1) step();
      w_en = 1'b0; w_rd_en = 1'b1;
      step();
      w_rd_en = 1'b0;
      chk(w_rd_data == {6'd1, 6'h3F}, "R4 before wrap", 64'(w_rd_data), 64'({6'd1, 6'h3F}));
      chk(w_rd_total == 6'd0, "R8 sum wraps", 64'(w_rd_total), 64'd0);
      w_en = 1'b1;
      repeat (n) step();
      w_en = 1'b0; w_rd_en = 1'b1;
      step();
      w_rd_en = 1'b0;
      chk(w_rd_data == {6'd1, 6'd0}, "R4 after wrap", 64'(w_rd_data), 64'({6'd1, 6'd0}));
      chk(w_rd_total == 6'd1, "R8 after wrap", 64'(w_rd_total), 64'd1);
    end

    summary();
    $finish;
  end

endmodule